// File: doc/BRIEF.md
# Register Command Frame Decoder

This block sits between a byte-wide serial receiver and a downstream serial configuration master. It watches a stream of received bytes, each marked by a one-cycle valid strobe. From that stream it assembles register access commands.

The first byte of a frame selects the access kind. It carries a single mode bit copied into all eight positions: 0x00 selects a read and 0xFF selects a write. A read frame has one more byte, the register address. A write frame has two more bytes, the address and then the value. When a frame is complete, the block presents the command on its outputs and keeps it there until the master takes it.

Partial frames are abandoned if the next byte arrives too late. Bytes that arrive while the master is busy are ignored, and so are bytes that arrive while a command is still waiting to be taken. The link that delivers the bytes normally runs at 9600 baud with 8 data bits, 1 stop bit, no parity and no flow control. That link is outside this block.

Top module: `cmd_frame_decoder`

## Requirements
- R1: Reset (synchronous, active high) clears `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_data` to zero and abandons any partial frame.
- R2: In the idle state, a byte 0x00 starts a read frame and a byte 0xFF starts a write frame. Any other byte is discarded and the block stays idle.
- R3: A write frame is the type byte 0xFF, then an address byte, then a value byte. It produces a command with `cmd_write`=1, `cmd_addr` equal to the second byte and `cmd_data` equal to the third byte.
- R4: A read frame is the type byte 0x00, then an address byte. It produces a command with `cmd_write`=0, `cmd_addr` equal to the second byte and `cmd_data`=0x00.
- R5: `cmd_valid` goes high in the cycle right after the clock edge that captures the final byte of a frame. Address and value bytes are taken as data whatever their value, including 0x00 and 0xFF.
- R6: While `cmd_valid` is high and `busy` is high, `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_data` hold their values. At the first edge where `cmd_valid` is high and `busy` is low, the command is taken, and `cmd_valid` is low in the next cycle.
- R7: A byte whose strobe coincides with `busy` high, or with `cmd_valid` high, is ignored. It neither starts, extends nor completes a frame.
- R8: Inside a frame, a byte whose capturing edge is at most `GAP_CYCLES` edges after the previous accepted byte continues the frame. If `GAP_CYCLES`+1 edges pass without a byte, the partial frame is dropped and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| busy | input | 1 | Downstream master is occupied; low means a pending command is taken |
| cmd_valid | output | 1 | A decoded command is presented |
| cmd_write | output | 1 | 1 for a write command, 0 for a read |
| cmd_addr | output | 8 | Register address |
| cmd_data | output | 8 | Write value; zero for reads |

## Verification
The bench sends address bytes equal to 0x00 and 0xFF. A decoder that re-reads them as type bytes would restart the frame and lose the command. It places a gap of exactly `GAP_CYCLES` edges and one of `GAP_CYCLES`+1 edges between bytes. An off-by-one timer would keep a stale frame, which then swallows later bytes, or it would cut off a frame that arrived in time. It sends a type byte while `busy` is high and again while a command is pending, and then sends bytes that show whether a frame was started. A decoder that listened at those times would emit a wrong write command or a wrong read command. It also holds `busy` high after a command is presented. A design that dropped or changed the command early would lose a register access.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } cfd_state_t;

  typedef struct packed {
    logic              write;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } cfd_cmd_t;
endpackage

// File: rtl/cfd_type_decode.sv
// Classifies a byte as a read marker (all zeros) or a write marker (all ones).
module cfd_type_decode #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] byte_in,
  output logic         is_rd,
  output logic         is_wr
);
  assign is_rd = ~|byte_in;
  assign is_wr = &byte_in;
endmodule

// File: rtl/cfd_gap_timer.sv
// Counts idle edges inside a frame; flags when the allowed gap is exceeded.
module cfd_gap_timer #(
  parameter int unsigned LIMIT = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && !clear && (cnt == LAST);
endmodule

// File: rtl/cfd_cmd_hold.sv
// Holds a finished command until the downstream master is free to take it.
module cfd_cmd_hold (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  cfd_pkg::cfd_cmd_t load_cmd,
  input  logic              busy,
  output logic              valid,
  output cfd_pkg::cfd_cmd_t cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cmd   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cmd   <= load_cmd;
    end else if (valid && !busy) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
  parameter int unsigned GAP_CYCLES = 65536
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_valid,
  input  logic [cfd_pkg::BYTE_W-1:0] rx_byte,
  input  logic                       busy,
  output logic                       cmd_valid,
  output logic                       cmd_write,
  output logic [cfd_pkg::BYTE_W-1:0] cmd_addr,
  output logic [cfd_pkg::BYTE_W-1:0] cmd_data
);
  import cfd_pkg::*;

  cfd_state_t        state;
  logic              wr_q;
  logic [BYTE_W-1:0] addr_q;
  logic              take;
  logic              is_rd, is_wr;
  logic              expired;
  logic              load;
  cfd_cmd_t          load_cmd;
  cfd_cmd_t          held;

  assign take = rx_valid && !busy && !cmd_valid;

  cfd_type_decode #(.W(BYTE_W)) u_type (
    .byte_in (rx_byte),
    .is_rd   (is_rd),
    .is_wr   (is_wr)
  );

  cfd_gap_timer #(.LIMIT(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .run     (state != ST_IDLE),
    .clear   (take),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take && (is_rd || is_wr)) begin
            wr_q  <= is_wr;
            state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (take) begin
            addr_q <= rx_byte;
            state  <= wr_q ? ST_DATA : ST_IDLE;
          end else if (expired) begin
            state <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (take || expired) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load           = take && (((state == ST_ADDR) && !wr_q) || (state == ST_DATA));
    load_cmd.write = wr_q;
    load_cmd.addr  = (state == ST_DATA) ? addr_q : rx_byte;
    load_cmd.data  = (state == ST_DATA) ? rx_byte : '0;
  end

  cfd_cmd_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_cmd (load_cmd),
    .busy     (busy),
    .valid    (cmd_valid),
    .cmd      (held)
  );

  assign cmd_write = held.write;
  assign cmd_addr  = held.addr;
  assign cmd_data  = held.data;
endmodule

// File: rtl/cmd_frame_decoder_chk.sv
module cmd_frame_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       busy,
  input logic       cmd_valid,
  input logic       cmd_write,
  input logic [7:0] cmd_addr,
  input logic [7:0] cmd_data
);
  assert_read_data_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_write) |-> (cmd_data == 8'h00));

  assert_rise_after_byte_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(rx_valid));

  assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_data)));

  assert_drop_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> !cmd_valid);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !$rose(cmd_valid));
endmodule

bind cmd_frame_decoder cmd_frame_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .busy      (busy),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data)
);

// File: tb/cmd_frame_decoder_tb.sv
module cmd_frame_decoder_tb;
  localparam int unsigned GAP = 20;
  localparam int NV = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       busy = 1'b0;
  logic       cmd_valid, cmd_write;
  logic [7:0] cmd_addr, cmd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic       got;
  logic       got_w;
  logic [7:0] got_a, got_d;

  always #2 clk = ~clk;

  cmd_frame_decoder #(.GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  // count, three bytes, expect-valid, expect-write, expect-addr, expect-data
  typedef struct packed {
    logic [1:0] n;
    logic [7:0] b0, b1, b2;
    logic       ev, ew;
    logic [7:0] ea, ed;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd3, 8'hFF, 8'h3C, 8'hA5, 1'b1, 1'b1, 8'h3C, 8'hA5},  // R3 write
    '{2'd2, 8'h00, 8'h7E, 8'h00, 1'b1, 1'b0, 8'h7E, 8'h00},  // R4 read
    '{2'd3, 8'h5A, 8'h00, 8'h81, 1'b1, 1'b0, 8'h81, 8'h00},  // R2 junk type then read
    '{2'd3, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1, 8'h00, 8'hFF},  // R5 marker-valued fields
    '{2'd2, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 8'hFF, 8'h00},  // R5 addr 0xFF on read
    '{2'd1, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00},  // R2 junk alone
    '{2'd3, 8'hFE, 8'h00, 8'h01, 1'b1, 1'b0, 8'h01, 8'h00}   // R2 near-marker junk
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    if (cmd_valid) begin
      got = 1'b1; got_w = cmd_write; got_a = cmd_addr; got_d = cmd_data;
    end
  endtask

  task automatic expect_cmd(input string req, input logic ew, input logic [7:0] ea, input logic [7:0] ed);
    chk(got && got_w == ew && got_a == ea && got_d == ed, req,
        {7'd0, got, 7'd0, got_w, got_a, got_d}, {8'd1, 7'd0, ew, ea, ed});
  endtask

  task automatic expect_none(input string req);
    chk(!got, req, {31'd0, got}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    got = 1'b0; got_w = 1'b0; got_a = '0; got_d = '0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!cmd_valid && !cmd_write && cmd_addr == 0 && cmd_data == 0, "R1 reset",
        {15'd0, cmd_valid, cmd_write, 7'd0, cmd_addr, cmd_data}, 32'd0);

    // Table of frames
    for (int i = 0; i < NV; i++) begin
      got = 1'b0;
      send_byte(VECS[i].b0);
      if (VECS[i].n > 1) send_byte(VECS[i].b1);
      if (VECS[i].n > 2) send_byte(VECS[i].b2);
      idle(2);
      if (VECS[i].ev) expect_cmd($sformatf("R2/R3/R4 vector %0d", i), VECS[i].ew, VECS[i].ea, VECS[i].ed);
      else            expect_none($sformatf("R2 vector %0d", i));
    end

    // R8: gap of exactly GAP edges is tolerated
    got = 1'b0;
    send_byte(8'hFF); idle(GAP - 1);
    send_byte(8'h10); idle(GAP - 1);
    send_byte(8'h20); idle(2);
    expect_cmd("R8 gap at limit", 1'b1, 8'h10, 8'h20);

    // R8: gap of GAP+1 edges drops the partial write frame
    got = 1'b0;
    send_byte(8'hFF); idle(GAP);
    send_byte(8'h10);
    send_byte(8'h20); idle(2);
    expect_none("R8 gap over limit");
    send_byte(8'h00); send_byte(8'h30); idle(2);
    expect_cmd("R8 idle after drop", 1'b0, 8'h30, 8'h00);

    // R7: type byte while busy is ignored
    got = 1'b0;
    busy = 1'b1;
    send_byte(8'hFF);
    busy = 1'b0;
    send_byte(8'h00); send_byte(8'h33); idle(2);
    expect_cmd("R7 busy byte ignored", 1'b0, 8'h33, 8'h00);

    // R5/R6: command held while busy
    got = 1'b0;
    send_byte(8'hFF); send_byte(8'h3C);
    rx_valid = 1'b1; rx_byte = 8'hA5;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    busy = 1'b1;
    chk(cmd_valid && cmd_write && cmd_addr == 8'h3C && cmd_data == 8'hA5, "R5 valid after last byte",
        {15'd0, cmd_valid, cmd_write, 7'd0, cmd_addr, cmd_data}, {15'd0, 1'b1, 1'b1, 7'd0, 8'h3C, 8'hA5});
    begin
      bit held_ok = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (!(cmd_valid && cmd_write && cmd_addr == 8'h3C && cmd_data == 8'hA5)) held_ok = 1'b0;
      end
      chk(held_ok, "R6 hold while busy", {31'd0, held_ok}, 32'd1);
    end
    // R7: byte during pending command with busy high
    send_byte(8'h00);
    chk(cmd_valid, "R6 still held", {31'd0, cmd_valid}, 32'd1);
    busy = 1'b0;
    @(negedge clk);
    chk(!cmd_valid, "R6 drop after accept", {31'd0, cmd_valid}, 32'd0);
    got = 1'b0;
    send_byte(8'h44); send_byte(8'h55); idle(2);
    expect_none("R7 byte during pending ignored");

    // R1: reset mid-frame abandons it
    got = 1'b0;
    send_byte(8'hFF); send_byte(8'h12);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    send_byte(8'h00); send_byte(8'h66); idle(2);
    expect_cmd("R1 reset mid-frame", 1'b0, 8'h66, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule